// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block timestamps edges on an external input. The raw pin passes through a two-stage synchronizer. An optional four-sample glitch filter may follow it, and after that comes an edge detector that picks rising or falling edges. On each detected edge, the block copies the count of an external free-running timer into a capture register and sets a capture flag. Software clears the flag by writing one to it, or the flag clears when the capture interrupt is acknowledged. The interrupt request is the flag qualified by an enable bit.

The filter runs on the undivided system clock. Its output moves to a new level only when four consecutive samples agree, so enabling it delays every capture by exactly four cycles. When the timer uses the capture register as its period limit, a mode input freezes the filter and the detector and suppresses all captures. Every pin is a plain level signal: no data crosses the edge of the block under flow control, so no port has back-pressure.

Top module: `icap_unit`

## Requirements
- R1: With the filter off, a pin level change first sampled at clock edge 1 produces its capture at edge 3. The register stores the timer value present at edge 3.
- R2: With the filter on, the same change is captured at edge 7, which is exactly four cycles later than with the filter off.
- R3: With the filter on, a pulse that lasts fewer than four clocks produces no capture. With the filter off, a one-clock pulse is captured.
- R4: With `edge_fall` = 0, only rising edges capture. With `edge_fall` = 1, only falling edges capture.
- R5: A new event overwrites an unread capture value, and the flag stays set.
- R6: A pulse on `flag_clr` clears the flag at the next edge. A capture event in the same cycle wins, and the flag stays set.
- R7: A pulse on `irq_ack` clears the flag in the same way as `flag_clr`.
- R8: `cap_irq` is high exactly when the flag is set and `irq_en` is high.
- R9: While `top_mode` is high, pin activity causes no capture, and the flag and capture register keep their values.
- R10: Changing `edge_fall` can itself produce a capture at the next edge. This happens when the newly selected edge's active level equals the current detector input: rising selected with the input high, or falling selected with the input low. The opposite switch produces none.
- R11: After reset, the capture register, the flag and the interrupt request are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Raw asynchronous capture input |
| tmr_count | input | CNT_W | Current timer count |
| filt_en | input | 1 | Enables the four-sample filter |
| edge_fall | input | 1 | 0 selects rising edges, 1 selects falling edges |
| top_mode | input | 1 | Capture register is timer period; captures disabled |
| flag_clr | input | 1 | Write-one pulse that clears the flag |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |
| irq_en | input | 1 | Capture interrupt enable |
| cap_value | output | CNT_W | Captured timer count |
| cap_flag | output | 1 | Capture flag |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
Single clean steps of the pin, with the filter off and then on, separate the two fixed latencies: the stored count identifies the exact edge at which the capture happened. Pulses of one to four clocks test the filter's agreement threshold. Both edge polarities, and switches of the edge selection at each input level, separate genuine edges from the modelled switch-induced capture. Random pin, mode and clear traffic then checks flag priority, overwrite and gating against a cycle model built from the requirements.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  // R1
  sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q == $past(stg[STAGES-2]));
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int HIST = LEN - 1;
  logic [HIST-1:0] hist;
  logic            fo;
  logic            all_hi, all_lo;

  assign all_hi = din & (&hist);
  assign all_lo = ~din & ~(|hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      fo   <= 1'b0;
    end else if (!hold) begin
      hist[0] <= din;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
      if (!en)         fo <= din;
      else if (all_hi) fo <= 1'b1;
      else if (all_lo) fo <= 1'b0;
    end
  end

  assign dout = en ? fo : din;

  // R2
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(hold) && (fo != $past(fo))) |-> (fo ? (&hist) : ~(|hist)));
endmodule

// File: rtl/icap_edge.sv
module icap_edge
  import icap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  edge_sel_e sel,
  input  logic      din,
  output logic      evt
);
  logic level, prev_q;

  assign level = din ^ (sel == EDGE_FALL);
  assign evt   = !hold && level && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (!hold) prev_q <= level;
  end

  // R4
  edge_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> prev_q);
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             filt_en,
  input  logic             edge_fall,
  input  logic             top_mode,
  input  logic             flag_clr,
  input  logic             irq_ack,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             cap_irq
);
  logic      pin_s, det_in, cap_evt;
  edge_sel_e sel;

  assign sel = edge_fall ? EDGE_FALL : EDGE_RISE;

  icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cap_pin), .q(pin_s));

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .hold(top_mode), .en(filt_en),
    .din(pin_s), .dout(det_in));

  icap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .hold(top_mode), .sel(sel),
    .din(det_in), .evt(cap_evt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else if (cap_evt) begin
      cap_value <= tmr_count;
      cap_flag  <= 1'b1;
    end else if (flag_clr || irq_ack) begin
      cap_flag  <= 1'b0;
    end
  end

  assign cap_irq = cap_flag & irq_en;

  // R5
  cap_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> cap_value == $past(tmr_count));
  // R9
  gated_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode |-> !cap_evt);
  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_evt) |=> !cap_flag);
  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cap_evt) |=> !cap_flag);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_irq |-> irq_en);
endmodule

// File: tb/icap_unit_tb.sv
module icap_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0, filt_en = 1'b0, edge_fall = 1'b0, top_mode = 1'b0;
  logic        flag_clr = 1'b0, irq_ack = 1'b0, irq_en = 1'b0;
  logic [15:0] tcnt = 16'h1000;
  logic [15:0] cap_value;
  logic        cap_flag, cap_irq;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) tcnt <= tcnt + 16'd1;

  icap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_count(tcnt),
    .filt_en(filt_en), .edge_fall(edge_fall), .top_mode(top_mode),
    .flag_clr(flag_clr), .irq_ack(irq_ack), .irq_en(irq_en),
    .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq));

  // cycle model built from the requirements
  logic [1:0]  m_s;
  logic [2:0]  m_h;
  logic        m_f, m_p, m_flag;
  logic [15:0] m_cap;

  function automatic logic m_det(input logic fe, input logic f, input logic s);
    return fe ? f : s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s <= '0; m_h <= '0; m_f <= 1'b0; m_p <= 1'b0; m_flag <= 1'b0; m_cap <= '0;
    end else begin
      logic lvl, ev;
      lvl = m_det(filt_en, m_f, m_s[1]) ^ edge_fall;
      ev  = !top_mode && lvl && !m_p;
      m_s <= {m_s[0], cap_pin};
      if (!top_mode) begin
        m_h <= {m_h[1:0], m_s[1]};
        if (!filt_en) m_f <= m_s[1];
        else if (m_s[1] && (&m_h)) m_f <= 1'b1;
        else if (!m_s[1] && !(|m_h)) m_f <= 1'b0;
        m_p <= lvl;
      end
      if (ev) begin m_cap <= tcnt; m_flag <= 1'b1; end
      else if (flag_clr || irq_ack) m_flag <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk); #1;
      if (rst_n) begin
        chk("R5 model value", cap_value, m_cap);
        chk("R6 model flag", cap_flag, m_flag);
        chk("R8 model irq", cap_irq, m_flag & irq_en);
      end
    end
  endtask

  task automatic pulse_clr();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] t0, t1;
    void'($urandom(32'd4242));
    @(negedge clk); #1;
    chk("R11 reset value", cap_value, 0);
    chk("R11 reset flag", cap_flag, 0);
    chk("R11 reset irq", cap_irq, 0);
    rst_n = 1'b1;
    tick(6);

    // R1 unfiltered latency
    cap_pin = 1'b1; t0 = tcnt;
    tick(2); chk("R1 no capture before edge 3", cap_flag, 0);
    tick(1); chk("R1 flag at edge 3", cap_flag, 1);
    chk("R1 stamp", cap_value, t0 + 16'd2);
    pulse_clr(); chk("R6 flag cleared", cap_flag, 0);

    // R4 falling edge ignored in rising mode
    cap_pin = 1'b0; tick(6); chk("R4 falling ignored", cap_flag, 0);
    // R10 switch to falling while input low -> capture
    edge_fall = 1'b1; t0 = tcnt; tick();
    chk("R10 switch capture flag", cap_flag, 1);
    chk("R10 switch capture stamp", cap_value, t0);
    pulse_clr();
    cap_pin = 1'b1; tick(6); chk("R4 rising ignored in falling mode", cap_flag, 0);
    cap_pin = 1'b0; t0 = tcnt; tick(3);
    chk("R4 falling captured", cap_flag, 1); chk("R4 falling stamp", cap_value, t0 + 16'd2);
    pulse_clr();
    edge_fall = 1'b0; tick(); chk("R10 opposite switch no capture", cap_flag, 0);

    // R2 filtered latency
    filt_en = 1'b1; tick(8);
    cap_pin = 1'b1; t0 = tcnt;
    tick(6); chk("R2 no capture before edge 7", cap_flag, 0);
    tick(1); chk("R2 flag at edge 7", cap_flag, 1);
    chk("R2 stamp", cap_value, t0 + 16'd6);

    // R8 interrupt gating
    irq_en = 1'b1; #1; chk("R8 irq on", cap_irq, 1);
    irq_en = 1'b0; #1; chk("R8 irq off", cap_irq, 0);
    irq_en = 1'b1;
    // R7 acknowledge clears
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R7 ack clears flag", cap_flag, 0); chk("R8 irq low", cap_irq, 0);

    // R3 short pulses
    cap_pin = 1'b0; tick(10);
    cap_pin = 1'b1; tick(3); cap_pin = 1'b0; tick(12);
    chk("R3 3-clock pulse rejected", cap_flag, 0);
    cap_pin = 1'b1; tick(4); cap_pin = 1'b0; tick(12);
    chk("R3 4-clock pulse passes", cap_flag, 1);
    pulse_clr();
    filt_en = 1'b0; tick(4);
    cap_pin = 1'b1; tick(1); cap_pin = 1'b0; tick(6);
    chk("R3 1-clock pulse unfiltered captured", cap_flag, 1);

    // R5 overwrite
    cap_pin = 1'b1; t1 = tcnt; tick(3);
    chk("R5 overwrite value", cap_value, t1 + 16'd2); chk("R5 flag kept", cap_flag, 1);
    pulse_clr();

    // R6 set beats clear
    cap_pin = 1'b0; tick(4);
    cap_pin = 1'b1; t0 = tcnt; tick(2);
    flag_clr = 1'b1; tick(); chk("R6 set wins over clear", cap_flag, 1);
    tick(); flag_clr = 1'b0; chk("R6 clear after", cap_flag, 0);

    // R9 gated mode
    t1 = cap_value;
    top_mode = 1'b1; cap_pin = 1'b0; tick(5);
    cap_pin = 1'b1; tick(5); cap_pin = 1'b0; tick(5); cap_pin = 1'b1; tick(5);
    cap_pin = 1'b0; tick(5);
    chk("R9 no flag when gated", cap_flag, 0);
    chk("R9 value held when gated", cap_value, t1);
    top_mode = 1'b0; tick(8);
    chk("R9 no capture after release", cap_flag, 0);

    // random traffic against the model
    for (int k = 0; k < 6000; k++) begin
      if ($urandom_range(0, 3) == 0) cap_pin = ~cap_pin;
      if ($urandom_range(0, 60) == 0) filt_en = ~filt_en;
      if ($urandom_range(0, 50) == 0) edge_fall = ~edge_fall;
      if ($urandom_range(0, 80) == 0) top_mode = ~top_mode;
      flag_clr = ($urandom_range(0, 9) == 0);
      irq_ack  = ($urandom_range(0, 12) == 0);
      irq_en   = ($urandom_range(0, 1) == 1);
      tick();
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule